// File: doc/BRIEF.md
# Migratory Sharing Detector and Converter

This block sits next to a directory and watches the request stream for each tracked line. When a line keeps moving from one processor to another, each new processor reading it and then writing it, the block counts those hand-offs. Once enough have been seen, it rewrites a plain read request for that line into a read-exclusive grant and flags the grant as migratory. The requester then holds the line exclusive at once, and it skips the shared fill that an upgrade would otherwise follow.

A small requester-side tracker is included. It keeps each line in one of three states: invalid, exclusive-migratory or exclusive. When a migratory grant is filled and then snooped by another processor before any local store, the migratory guess was wrong. The tracker raises a break report, and the directory side uses that report to withdraw the conversion for the line. A line whose conversion is withdrawn too many times is locked out of conversion for good. Both thresholds are parameters, and every line keeps its own state.

Top module: `migDetect`

## Requirements
- R1: After reset, outValid and brkValid are 0, and no line is converted: a read on any line comes out as kind 0 with outMig 0.
- R2: A line becomes converted once CONV_THRESH (default 2) migratory events have been counted for it. A single event does not convert it.
- R3: Request kinds are encoded as 0 read, 1 read-exclusive, 2 upgrade, 3 other. One cycle after a request, outValid is 1. A read on a converted line comes out as kind 1 with outMig 1. Every other request passes its kind through unchanged with outMig 0.
- R4: A migratory event is a kind 1 or kind 2 request whose reqProc differs from dirOwner while dirSharers holds exactly the bit of dirOwner. Requests from the owner itself, or with any other sharer pattern, are not counted.
- R5: A fill with fillMig 1 puts the line into exclusive-migratory. A snoop on a line in that state raises brkValid one cycle later, with brkLine equal to the snooped line, and the line becomes invalid.
- R6: A local store on an exclusive-migratory line moves it to plain exclusive, so a later snoop gives no break. A fill with fillMig 0 also gives no break on snoop.
- R7: A break report on a converted line clears its conversion and its event count. A break report on a line that is not converted has no effect.
- R8: After REVERT_THRESH (default 3) reverts, the line is never converted again, whatever events follow.
- R9: If a revert lands in the same cycle as a read to the same line, the revert wins and the read is not converted.
- R10: Each line keeps its own counters and flags. Activity on one line never changes how another line is treated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Directory request present |
| reqLine | input | LINE_W | Line addressed by the request |
| reqProc | input | PROC_W | Requesting processor |
| reqKind | input | 2 | Request kind (0 read, 1 read-exclusive, 2 upgrade, 3 other) |
| dirOwner | input | PROC_W | Last writer of the line, as held in the directory |
| dirSharers | input | NUM_PROCS | Processors currently holding the line |
| outValid | output | 1 | Converted request present |
| outKind | output | 2 | Request kind after conversion |
| outMig | output | 1 | Grant must be cached exclusive-migratory |
| fillValid | input | 1 | Requester-side fill |
| fillLine | input | LINE_W | Line being filled |
| fillMig | input | 1 | Fill carries the migratory mark |
| storeValid | input | 1 | Local store |
| storeLine | input | LINE_W | Line stored to |
| snpValid | input | 1 | Request from another processor reaches this requester |
| snpLine | input | LINE_W | Snooped line |
| brkValid | output | 1 | Break report to the home |
| brkLine | output | LINE_W | Line whose migratory guess broke |

## Verification
A revert and a read conversion can fall on the same clock edge for the same line. This happens when the break report, which is registered, leaves the requester side in the cycle in which a read for that line is issued. The bench provokes it on a converted line: it snoops the line, then drives the read in the very next cycle, so that the read's edge is the one at which the revert is applied. The read must come out unconverted. Later reads must also stay unconverted until the event count has been rebuilt from zero.

// File: rtl/migPkg.sv
package migPkg;

  typedef enum logic [1:0] {
    KIND_READ    = 2'd0,
    KIND_READEX  = 2'd1,
    KIND_UPGRADE = 2'd2,
    KIND_OTHER   = 2'd3
  } reqKind_e;

  typedef enum logic [1:0] {
    RS_INV   = 2'd0,
    RS_EXMIG = 2'd1,
    RS_EXCL  = 2'd2
  } rsState_e;

  // strobes from control to the per-line state datapath
  typedef struct packed {
    logic bumpEvt;
    logic setConv;
    logic clrConv;
    logic bumpRev;
    logic setDis;
  } migStrobe_t;

endpackage

// File: rtl/migReqSide.sv
module migReqSide
  import migPkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int LINE_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fillValid,
  input  logic [LINE_W-1:0] fillLine,
  input  logic              fillMig,
  input  logic              storeValid,
  input  logic [LINE_W-1:0] storeLine,
  input  logic              snpValid,
  input  logic [LINE_W-1:0] snpLine,
  output logic              brkValid,
  output logic [LINE_W-1:0] brkLine
);

  logic [NUM_LINES-1:0] brkHit;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    rsState_e state;
    logic     snpHere, storeHere, fillHere;

    assign snpHere   = snpValid   && (snpLine   == LINE_W'(i));
    assign storeHere = storeValid && (storeLine == LINE_W'(i));
    assign fillHere  = fillValid  && (fillLine  == LINE_W'(i));
    assign brkHit[i] = snpHere && (state == RS_EXMIG);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        state <= RS_INV;
      end else begin
        if (snpHere) begin
          state <= RS_INV;
        end else if (storeHere && state == RS_EXMIG) begin
          state <= RS_EXCL;
        end
        if (fillHere) begin
          state <= fillMig ? RS_EXMIG : RS_EXCL;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      brkValid <= 1'b0;
      brkLine  <= '0;
    end else begin
      brkValid <= |brkHit;
      brkLine  <= snpLine;
    end
  end

endmodule

// File: rtl/migDatapath.sv
module migDatapath
  import migPkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int LINE_W    = 2,
  parameter int CNT_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  migStrobe_t        strobe,
  input  logic [LINE_W-1:0] reqLine,
  input  logic [LINE_W-1:0] brkLine,
  output logic              convR,
  output logic              disR,
  output logic [CNT_W-1:0]  evtR,
  output logic              convB,
  output logic [CNT_W-1:0]  revB,
  output logic [NUM_LINES-1:0] disVec
);

  logic [NUM_LINES-1:0]            convVec;
  logic [NUM_LINES-1:0][CNT_W-1:0] evtVec;
  logic [NUM_LINES-1:0][CNT_W-1:0] revVec;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic             conv, dis;
    logic [CNT_W-1:0] evtCnt, revCnt;
    logic             atReq, atBrk;

    assign atReq = (reqLine == LINE_W'(i));
    assign atBrk = (brkLine == LINE_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        conv   <= 1'b0;
        dis    <= 1'b0;
        evtCnt <= '0;
        revCnt <= '0;
      end else begin
        if (strobe.clrConv && atBrk) begin
          conv   <= 1'b0;
          evtCnt <= '0;
          if (strobe.bumpRev) revCnt <= revCnt + 1'b1;
          if (strobe.setDis)  dis    <= 1'b1;
        end
        if (strobe.bumpEvt && atReq) evtCnt <= evtCnt + 1'b1;
        if (strobe.setConv && atReq) conv   <= 1'b1;
      end
    end

    assign convVec[i] = conv;
    assign disVec[i]  = dis;
    assign evtVec[i]  = evtCnt;
    assign revVec[i]  = revCnt;
  end

  assign convR = convVec[reqLine];
  assign disR  = disVec[reqLine];
  assign evtR  = evtVec[reqLine];
  assign convB = convVec[brkLine];
  assign revB  = revVec[brkLine];

endmodule

// File: rtl/migControl.sv
module migControl
  import migPkg::*;
#(
  parameter int NUM_PROCS     = 4,
  parameter int LINE_W        = 2,
  parameter int PROC_W        = 2,
  parameter int CNT_W         = 2,
  parameter int CONV_THRESH   = 2,
  parameter int REVERT_THRESH = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [LINE_W-1:0]    reqLine,
  input  logic [PROC_W-1:0]    reqProc,
  input  logic [1:0]           reqKind,
  input  logic [PROC_W-1:0]    dirOwner,
  input  logic [NUM_PROCS-1:0] dirSharers,
  input  logic                 brkValid,
  input  logic [LINE_W-1:0]    brkLine,
  input  logic                 convR,
  input  logic                 disR,
  input  logic [CNT_W-1:0]     evtR,
  input  logic                 convB,
  input  logic [CNT_W-1:0]     revB,
  output migStrobe_t           strobe,
  output logic                 outValid,
  output logic [1:0]           outKind,
  output logic                 outMig
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NUM_PROCS-1:0] ownerMask;
  logic isWrite, migEvt, revertHit, sameLine, convLive;

  assign ownerMask = {{(NUM_PROCS-1){1'b0}}, 1'b1} << dirOwner;
  assign isWrite   = (reqKind == KIND_READEX) || (reqKind == KIND_UPGRADE);
  assign sameLine  = reqValid && brkValid && (reqLine == brkLine);
  assign revertHit = brkValid && convB;

  // a same-line revert in this cycle withdraws the conversion first
  assign convLive  = convR && !(sameLine && revertHit);

  assign migEvt = reqValid && isWrite && (reqProc != dirOwner) &&
                  (dirSharers == ownerMask) && !convR && !disR;

  always_comb begin
    strobe.bumpEvt = migEvt && (evtR != CNT_MAX);
    strobe.setConv = migEvt && ((int'(evtR) + 1) >= CONV_THRESH);
    strobe.clrConv = revertHit;
    strobe.bumpRev = revertHit && (revB != CNT_MAX);
    strobe.setDis  = revertHit && ((int'(revB) + 1) >= REVERT_THRESH);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outKind  <= 2'd0;
      outMig   <= 1'b0;
    end else begin
      outValid <= reqValid;
      if (reqValid && reqKind == KIND_READ && convLive) begin
        outKind <= KIND_READEX;
        outMig  <= 1'b1;
      end else begin
        outKind <= reqValid ? reqKind : 2'd0;
        outMig  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/migDetect.sv
module migDetect
  import migPkg::*;
#(
  parameter int NUM_LINES     = 4,
  parameter int NUM_PROCS     = 4,
  parameter int CNT_W         = 2,
  parameter int CONV_THRESH   = 2,
  parameter int REVERT_THRESH = 3,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int PROC_W = (NUM_PROCS > 1) ? $clog2(NUM_PROCS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [LINE_W-1:0]    reqLine,
  input  logic [PROC_W-1:0]    reqProc,
  input  logic [1:0]           reqKind,
  input  logic [PROC_W-1:0]    dirOwner,
  input  logic [NUM_PROCS-1:0] dirSharers,
  output logic                 outValid,
  output logic [1:0]           outKind,
  output logic                 outMig,
  input  logic                 fillValid,
  input  logic [LINE_W-1:0]    fillLine,
  input  logic                 fillMig,
  input  logic                 storeValid,
  input  logic [LINE_W-1:0]    storeLine,
  input  logic                 snpValid,
  input  logic [LINE_W-1:0]    snpLine,
  output logic                 brkValid,
  output logic [LINE_W-1:0]    brkLine
);

  migStrobe_t           strobe;
  logic                 convR, disR, convB;
  logic [CNT_W-1:0]     evtR, revB;
  logic [NUM_LINES-1:0] disVec;

  migReqSide #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_req (
    .clk(clk), .rstN(rstN),
    .fillValid(fillValid), .fillLine(fillLine), .fillMig(fillMig),
    .storeValid(storeValid), .storeLine(storeLine),
    .snpValid(snpValid), .snpLine(snpLine),
    .brkValid(brkValid), .brkLine(brkLine)
  );

  migControl #(
    .NUM_PROCS(NUM_PROCS), .LINE_W(LINE_W), .PROC_W(PROC_W), .CNT_W(CNT_W),
    .CONV_THRESH(CONV_THRESH), .REVERT_THRESH(REVERT_THRESH)
  ) u_ctl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqLine(reqLine), .reqProc(reqProc), .reqKind(reqKind),
    .dirOwner(dirOwner), .dirSharers(dirSharers),
    .brkValid(brkValid), .brkLine(brkLine),
    .convR(convR), .disR(disR), .evtR(evtR), .convB(convB), .revB(revB),
    .strobe(strobe),
    .outValid(outValid), .outKind(outKind), .outMig(outMig)
  );

  migDatapath #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqLine(reqLine), .brkLine(brkLine),
    .convR(convR), .disR(disR), .evtR(evtR), .convB(convB), .revB(revB),
    .disVec(disVec)
  );

endmodule

// File: rtl/migDetectChecker.sv
module migDetectChecker #(
  parameter int NUM_LINES = 4,
  parameter int LINE_W    = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic [LINE_W-1:0]    reqLine,
  input logic [1:0]           reqKind,
  input logic                 snpValid,
  input logic [LINE_W-1:0]    snpLine,
  input logic                 brkValid,
  input logic [LINE_W-1:0]    brkLine,
  input logic                 outValid,
  input logic [1:0]           outKind,
  input logic                 outMig,
  input logic [NUM_LINES-1:0] disVec
);

  p_grant_kind_r3: assert property (@(posedge clk) disable iff (!rstN)
    outMig |-> (outValid && outKind == 2'd1));

  p_grant_from_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    outMig |-> $past(reqValid && reqKind == 2'd0));

  p_brk_after_snoop_r5: assert property (@(posedge clk) disable iff (!rstN)
    brkValid |-> ($past(snpValid) && $past(snpLine) == brkLine));

  p_disable_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (($past(disVec) & ~disVec) == '0));

  p_no_grant_disabled_r8: assert property (@(posedge clk) disable iff (!rstN)
    outMig |-> !$past(disVec[reqLine]));

  p_revert_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    outMig |-> !$past(brkValid && brkLine == reqLine));

endmodule

bind migDetect migDetectChecker #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLine(reqLine), .reqKind(reqKind),
  .snpValid(snpValid), .snpLine(snpLine), .brkValid(brkValid), .brkLine(brkLine),
  .outValid(outValid), .outKind(outKind), .outMig(outMig), .disVec(disVec)
);

// File: tb/migDetect_bench.sv
module migDetect_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0; logic [1:0] reqLine = 0, reqProc = 0, reqKind = 0, dirOwner = 0;
  logic [NP-1:0] dirSharers = 0;
  logic outValid, outMig; logic [1:0] outKind;
  logic fillValid = 0, fillMig = 0, storeValid = 0, snpValid = 0;
  logic [1:0] fillLine = 0, storeLine = 0, snpLine = 0;
  logic brkValid; logic [1:0] brkLine;

  int nTests = 0, nFails = 0;
  bit finished = 0;
  int mEvt[NL], mRev[NL], mConv[NL], mDis[NL];

  always #(CLK_PERIOD/2) clk = ~clk;

  migDetect u_migDetect (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLine(reqLine), .reqProc(reqProc),
    .reqKind(reqKind), .dirOwner(dirOwner), .dirSharers(dirSharers),
    .outValid(outValid), .outKind(outKind), .outMig(outMig),
    .fillValid(fillValid), .fillLine(fillLine), .fillMig(fillMig),
    .storeValid(storeValid), .storeLine(storeLine),
    .snpValid(snpValid), .snpLine(snpLine), .brkValid(brkValid), .brkLine(brkLine)
  );

  task automatic chk(string tag, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    for (int i = 0; i < NL; i++) begin mEvt[i] = 0; mRev[i] = 0; mConv[i] = 0; mDis[i] = 0; end
    @(negedge clk);
  endtask

  // drive a request at a negedge, sample the registered result one edge later
  task automatic doReq(int line, int proc, int kind, int owner, logic [NP-1:0] sh,
                       int expKind, int expMig, string tag);
    reqValid = 1; reqLine = 2'(line); reqProc = 2'(proc); reqKind = 2'(kind);
    dirOwner = 2'(owner); dirSharers = sh;
    @(negedge clk);
    reqValid = 0;
    chk({tag, " valid"}, int'(outValid), 1);
    chk({tag, " kind"}, int'(outKind), expKind);
    chk({tag, " mig"}, int'(outMig), expMig);
  endtask

  task automatic modelRevert(int line);
    if (mConv[line] == 1) begin
      mConv[line] = 0; mEvt[line] = 0;
      if (mRev[line] < 3) mRev[line]++;
      if (mRev[line] >= 3) mDis[line] = 1;
    end
  endtask

  // qualifying migratory upgrade (R4 rule); upgrade passes unchanged (R3)
  task automatic migWrite(int line, string tag);
    int o = (line + 1) % NP;
    doReq(line, (o + 1) % NP, 2, o, NP'(1) << o, 2, 0, tag);
    if (mConv[line] == 0 && mDis[line] == 0) begin
      if (mEvt[line] < 3) mEvt[line]++;
      if (mEvt[line] >= 2) mConv[line] = 1;
    end
  endtask

  task automatic readChk(int line, string tag);
    int c = (mConv[line] == 1 && mDis[line] == 0) ? 1 : 0;
    doReq(line, 0, 0, 1, 4'b0010, c, c, tag);
  endtask

  task automatic brkCycle(int line, int mig, int doStore, int expBrk, string tag);
    fillValid = 1; fillLine = 2'(line); fillMig = 1'(mig);
    @(negedge clk); fillValid = 0;
    if (doStore != 0) begin
      storeValid = 1; storeLine = 2'(line);
      @(negedge clk); storeValid = 0;
    end
    snpValid = 1; snpLine = 2'(line);
    @(negedge clk); snpValid = 0;
    chk({tag, " brkValid"}, int'(brkValid), expBrk);
    if (expBrk != 0) chk({tag, " brkLine"}, int'(brkLine), line);
    @(negedge clk);
    if (expBrk != 0) modelRevert(line);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    doReset();
    chk("R1 outValid after reset", int'(outValid), 0);
    chk("R1 brkValid after reset", int'(brkValid), 0);
    for (int l = 0; l < NL; l++) readChk(l, "R1 fresh read");

    // R2 threshold, R3 conversion, R9 collision on line 0
    migWrite(0, "R4 event1");
    readChk(0, "R2 one event no conversion");
    migWrite(0, "R4 event2");
    readChk(0, "R2 R3 converted read");
    fillValid = 1; fillLine = 0; fillMig = 1;
    @(negedge clk); fillValid = 0;
    snpValid = 1; snpLine = 0;
    @(negedge clk); snpValid = 0;
    chk("R5 brk before collision", int'(brkValid), 1);
    doReq(0, 0, 0, 1, 4'b0010, 0, 0, "R9 read meets revert");
    modelRevert(0);
    readChk(0, "R7 conversion cleared");
    migWrite(0, "R7 event after revert");
    readChk(0, "R7 count restarted");

    // R4 non-qualifying writes on line 1
    doReq(1, 2, 2, 2, 4'b0100, 2, 0, "R4 owner writes");
    doReq(1, 2, 1, 2, 4'b0100, 1, 0, "R4 owner readex");
    doReq(1, 3, 2, 2, 4'b1100, 2, 0, "R4 two sharers");
    doReq(1, 3, 1, 2, 4'b0000, 1, 0, "R4 no sharers");
    readChk(1, "R4 line1 unconverted");

    // R10 independence and R6 requester side on line 2
    migWrite(2, "R10 l2 e1");
    migWrite(2, "R10 l2 e2");
    readChk(2, "R10 line2 converted");
    readChk(3, "R10 line3 untouched");
    readChk(1, "R10 line1 untouched");
    brkCycle(2, 1, 1, 0, "R6 store before snoop");
    brkCycle(2, 0, 0, 0, "R6 plain fill");
    readChk(2, "R6 line2 still converted");
    doReq(2, 1, 1, 0, 4'b0001, 1, 0, "R3 readex passes");
    doReq(2, 1, 3, 0, 4'b0001, 3, 0, "R3 other passes");

    // sweep all lines through repeated convert/revert rounds (R7, R8)
    doReset();
    for (int l = 0; l < NL; l++) begin
      for (int r = 0; r < 5; r++) begin
        brkCycle(l, 1, 0, 1, "R7 break on unconverted");
        migWrite(l, "R8 sweep e1");
        readChk(l, "R8 sweep after e1");
        migWrite(l, "R8 sweep e2");
        readChk(l, "R8 sweep after e2");
        brkCycle(l, 1, 0, 1, "R5 R7 sweep break");
        readChk(l, "R8 sweep after revert");
      end
      chk("R8 line disabled", mDis[l], 1);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule